// File: doc/BRIEF.md
# Linear CCD Line-Clock Sequencer

This block turns a fast system clock into the complete set of drive clocks for a three-colour linear CCD sensor. It produces three transfer-gate pulses with identical timing, two complementary shift-register phases, and a reset-gate pulse that marks every pixel period. Each line starts with a charge-transfer phase, followed by a readout of a programmable number of pixel periods. In the transfer phase the gates open inside a window that has setup and hold guards. The reset gate keeps pulsing during the transfer phase as well.

A downstream capture stage gets a per-pixel qualifier along with the clocks. The qualifier gives the pixel's region (leading dummy, optical black, invalid, valid, trailing invalid, or extra dummy) and carries a sample strobe at the middle of the reset-low interval. A strobe marks the first pixel of every readout. Software supplies four timing counts: pixel period, transfer width, guard interval and line length. The block captures them during reset and raises any count below its floor. The floors follow from the clock period and the sensor's minimum widths. A run input lets the current line complete before the clocks park.

Top module: `ccd_line_sequencer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, the outputs are `shift_ph1`=1, `shift_ph2`=0, all transfer gates 0, `reset_gate`=0, `line_start`=0, `sample_en`=0 and `pix_region`=0.
- R2: The four cfg inputs are captured only while `rst` is high; later changes to them have no effect. The effective pixel period is max(cfg, 13), the transfer width max(cfg, 150), the guard max(cfg, 45) and the line length max(cfg, pixel total). These floors apply at the default 20 ns clock. Readout delivers exactly the effective line length of pixels per line.
- R3: While running, `reset_gate` rises once every effective pixel period and stays high for 3 cycles each time. This holds without a gap through both the transfer phase and the readout phase.
- R4: `shift_ph2` is always the inverse of `shift_ph1`. During readout, `shift_ph1` equals bit 0 of the readout pixel index, so it is low on the first pixel. It changes only in a cycle where `reset_gate` rises.
- R5: The red, green and blue gates are identical. Each pulse is high for exactly the effective transfer width and only while `shift_ph1` is high. It rises a guard interval after the transfer phase starts, which is L×P cycles after the previous `line_start`. The next `line_start` comes X×P−G−T cycles after the fall, where X = ceil((2G+T)/P).
- R6: `pix_region` codes are 0 for dummy, 1 for optical black, 2 for invalid and 3 for valid. A readout line gives, in this order: N_DUMMY dummy, N_BLACK black, N_INV_LEAD invalid, N_VALID valid, N_INV_TRAIL invalid, then dummy for the remaining pixels.
- R7: `sample_en` pulses once per readout pixel, RS+floor((P−RS)/2) cycles after that pixel's reset rise (RS=3), while `reset_gate` is low.
- R8: `line_start` is a one-cycle pulse that coincides with the reset rise of readout pixel 0. Consecutive pulses are (X+L)×P cycles apart.
- R9: The block stays idle until `run` is high. Once `run` goes low, the current line reads out completely. No new line starts, and the outputs hold `shift_ph1`=1, `shift_ph2`=0, gates low and `reset_gate` low until `run` returns. When `run` returns, a new line starts.
- R10: When a shift phase changes, at least 6 cycles (110 ns) have passed since `reset_gate` last fell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; cfg captured while high |
| run | input | 1 | Run request, sampled at line end |
| cfg_pix_cycles | input | CW | Pixel period in clock cycles |
| cfg_tg_cycles | input | CW | Transfer-gate high width in cycles |
| cfg_guard_cycles | input | CW | Phase-1 guard before and after the gate pulse |
| cfg_line_pixels | input | CW | Readout pixel periods per line |
| shift_ph1 | output | 1 | Shift-register phase 1 |
| shift_ph2 | output | 1 | Shift-register phase 2, complement of phase 1 |
| tg_red | output | 1 | Red transfer gate |
| tg_green | output | 1 | Green transfer gate |
| tg_blue | output | 1 | Blue transfer gate |
| reset_gate | output | 1 | Per-pixel reset-gate pulse |
| line_start | output | 1 | First readout pixel strobe |
| pix_region | output | 2 | Region code of the current readout pixel |
| sample_en | output | 1 | Capture strobe in the middle of reset-low |

## Verification
The assertions take two things for granted. The timing counts must be stable during the reset cycles, because that is when they are latched. The counts must also fit CW bits so that twice the guard plus the gate width cannot wrap. The stimulus changes the cfg inputs only while reset is asserted, or after release to confirm that they are ignored. The random ranges reach above and below each floor but stay far below the counter width, and the run input is toggled only on the falling clock edge.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [1:0] {
    REG_DUMMY   = 2'd0,
    REG_BLACK   = 2'd1,
    REG_INVALID = 2'd2,
    REG_VALID   = 2'd3
  } pix_region_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_XFER = 2'd1,
    PH_READ = 2'd2
  } line_phase_t;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ccd_cfg_clamp.sv
module ccd_cfg_clamp #(
  parameter int CW        = 16,
  parameter int MIN_PIX   = 13,
  parameter int MIN_TG    = 150,
  parameter int MIN_GUARD = 45,
  parameter int MIN_LINE  = 26
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cfg_pix,
  input  logic [CW-1:0] cfg_tg,
  input  logic [CW-1:0] cfg_guard,
  input  logic [CW-1:0] cfg_line,
  output logic [CW-1:0] pix_q,
  output logic [CW-1:0] tg_q,
  output logic [CW-1:0] guard_q,
  output logic [CW-1:0] line_q
);

  localparam logic [CW-1:0] LO_PIX   = CW'(MIN_PIX);
  localparam logic [CW-1:0] LO_TG    = CW'(MIN_TG);
  localparam logic [CW-1:0] LO_GUARD = CW'(MIN_GUARD);
  localparam logic [CW-1:0] LO_LINE  = CW'(MIN_LINE);

  function automatic logic [CW-1:0] raise_to(input logic [CW-1:0] v,
                                             input logic [CW-1:0] lo);
    return (v < lo) ? lo : v;
  endfunction

  // Counts are latched only while reset is held; afterwards they are frozen.
  always_ff @(posedge clk) begin
    if (rst) begin
      pix_q   <= raise_to(cfg_pix, LO_PIX);
      tg_q    <= raise_to(cfg_tg, LO_TG);
      guard_q <= raise_to(cfg_guard, LO_GUARD);
      line_q  <= raise_to(cfg_line, LO_LINE);
    end
  end

endmodule

// File: rtl/ccd_pix_timer.sv
module ccd_pix_timer #(
  parameter int CW     = 16,
  parameter int RS_CYC = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic [CW-1:0] pix_len,
  output logic [CW-1:0] cnt,
  output logic          pix_last,
  output logic          rs_on,
  output logic          samp_pt
);

  localparam logic [CW-1:0] RS_W = CW'(RS_CYC);

  logic [CW-1:0] mid_pt;

  assign mid_pt   = RS_W + ((pix_len - RS_W) >> 1);
  assign pix_last = active && (cnt == pix_len - CW'(1));
  assign rs_on    = active && (cnt < RS_W);
  assign samp_pt  = active && (cnt == mid_pt);

  always_ff @(posedge clk) begin
    if (rst || !active) cnt <= '0;
    else if (pix_last)  cnt <= '0;
    else                cnt <= cnt + CW'(1);
  end

  // R3: the in-pixel counter never runs past the latched period
  a_r3_cnt_in_period: assert property (@(posedge clk) disable iff (rst)
    cnt < pix_len);

endmodule

// File: rtl/ccd_line_ctrl.sv
module ccd_line_ctrl
  import ccd_seq_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          pix_last,
  input  logic [CW-1:0] guard_len,
  input  logic [CW-1:0] tg_len,
  input  logic [CW-1:0] line_len,
  output line_phase_t   phase,
  output logic [CW-1:0] pix_idx,
  output logic          tg_on
);

  localparam int XW = CW + 2;

  logic [XW-1:0] xcnt_q;
  logic [XW-1:0] g_w, t_w, xfer_end;

  assign g_w      = XW'(guard_len);
  assign t_w      = XW'(tg_len);
  assign xfer_end = g_w + g_w + t_w - XW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      xcnt_q  <= '0;
      pix_idx <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (run) begin
            phase  <= PH_XFER;
            xcnt_q <= '0;
          end
        end
        PH_XFER: begin
          if (xcnt_q != '1) xcnt_q <= xcnt_q + XW'(1);
          // leave on a pixel boundary once guard+width+guard has elapsed
          if (pix_last && (xcnt_q >= xfer_end)) begin
            phase   <= PH_READ;
            pix_idx <= '0;
          end
        end
        PH_READ: begin
          if (pix_last) begin
            if (pix_idx == line_len - CW'(1)) begin
              pix_idx <= '0;
              xcnt_q  <= '0;
              phase   <= run ? PH_XFER : PH_IDLE;
            end else begin
              pix_idx <= pix_idx + CW'(1);
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign tg_on = (phase == PH_XFER) && (xcnt_q >= g_w) && (xcnt_q < g_w + t_w);

  // R6: the readout index stays inside the latched line length
  a_r6_idx_in_line: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_READ) |-> (pix_idx < line_len));

endmodule

// File: rtl/ccd_region_map.sv
module ccd_region_map
  import ccd_seq_pkg::*;
#(
  parameter int CW          = 16,
  parameter int N_DUMMY     = 14,
  parameter int N_BLACK     = 49,
  parameter int N_INV_LEAD  = 2,
  parameter int N_VALID     = 5300,
  parameter int N_INV_TRAIL = 3
) (
  input  logic [CW-1:0] pix_idx,
  output pix_region_t   region
);

  localparam logic [CW-1:0] END_DUMMY = CW'(N_DUMMY);
  localparam logic [CW-1:0] END_BLACK = CW'(N_DUMMY + N_BLACK);
  localparam logic [CW-1:0] END_ILEAD = CW'(N_DUMMY + N_BLACK + N_INV_LEAD);
  localparam logic [CW-1:0] END_VALID = CW'(N_DUMMY + N_BLACK + N_INV_LEAD + N_VALID);
  localparam logic [CW-1:0] END_ITRL  = CW'(N_DUMMY + N_BLACK + N_INV_LEAD + N_VALID + N_INV_TRAIL);

  always_comb begin
    if      (pix_idx < END_DUMMY) region = REG_DUMMY;
    else if (pix_idx < END_BLACK) region = REG_BLACK;
    else if (pix_idx < END_ILEAD) region = REG_INVALID;
    else if (pix_idx < END_VALID) region = REG_VALID;
    else if (pix_idx < END_ITRL)  region = REG_INVALID;
    else                          region = REG_DUMMY;
  end

endmodule

// File: rtl/ccd_line_sequencer.sv
module ccd_line_sequencer
  import ccd_seq_pkg::*;
#(
  parameter int CW           = 16,
  parameter int CLK_NS       = 20,
  parameter int PIX_MIN_NS   = 250,
  parameter int RS_HI_NS     = 50,
  parameter int RS_GAP_NS    = 110,
  parameter int TG_MIN_NS    = 3000,
  parameter int GUARD_MIN_NS = 900,
  parameter int N_DUMMY      = 14,
  parameter int N_BLACK      = 49,
  parameter int N_INV_LEAD   = 2,
  parameter int N_VALID      = 5300,
  parameter int N_INV_TRAIL  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] cfg_pix_cycles,
  input  logic [CW-1:0] cfg_tg_cycles,
  input  logic [CW-1:0] cfg_guard_cycles,
  input  logic [CW-1:0] cfg_line_pixels,
  output logic          shift_ph1,
  output logic          shift_ph2,
  output logic          tg_red,
  output logic          tg_green,
  output logic          tg_blue,
  output logic          reset_gate,
  output logic          line_start,
  output logic [1:0]    pix_region,
  output logic          sample_en
);

  localparam int RS_CYC    = cdiv(RS_HI_NS, CLK_NS);
  localparam int GAP_CYC   = cdiv(RS_GAP_NS, CLK_NS);
  localparam int MIN_PIX   = imax(cdiv(PIX_MIN_NS, CLK_NS), RS_CYC + GAP_CYC);
  localparam int MIN_TG    = cdiv(TG_MIN_NS, CLK_NS);
  localparam int MIN_GUARD = cdiv(GUARD_MIN_NS, CLK_NS);
  localparam int N_TOTAL   = N_DUMMY + N_BLACK + N_INV_LEAD + N_VALID + N_INV_TRAIL;
  localparam int N_COLOUR  = 3;

  logic [CW-1:0] pix_len, tg_len, guard_len, line_len;
  logic [CW-1:0] pix_cnt, pix_idx;
  logic          pix_last, rs_on, samp_pt, tg_on, active;
  line_phase_t   phase;
  pix_region_t   region_c;
  logic          ph1_next, first_pix;
  logic [N_COLOUR-1:0] tg_q;

  ccd_cfg_clamp #(
    .CW(CW), .MIN_PIX(MIN_PIX), .MIN_TG(MIN_TG),
    .MIN_GUARD(MIN_GUARD), .MIN_LINE(N_TOTAL)
  ) u_clamp (
    .clk(clk), .rst(rst),
    .cfg_pix(cfg_pix_cycles), .cfg_tg(cfg_tg_cycles),
    .cfg_guard(cfg_guard_cycles), .cfg_line(cfg_line_pixels),
    .pix_q(pix_len), .tg_q(tg_len), .guard_q(guard_len), .line_q(line_len)
  );

  assign active = (phase != PH_IDLE);

  ccd_pix_timer #(.CW(CW), .RS_CYC(RS_CYC)) u_timer (
    .clk(clk), .rst(rst), .active(active), .pix_len(pix_len),
    .cnt(pix_cnt), .pix_last(pix_last), .rs_on(rs_on), .samp_pt(samp_pt)
  );

  ccd_line_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .run(run), .pix_last(pix_last),
    .guard_len(guard_len), .tg_len(tg_len), .line_len(line_len),
    .phase(phase), .pix_idx(pix_idx), .tg_on(tg_on)
  );

  ccd_region_map #(
    .CW(CW), .N_DUMMY(N_DUMMY), .N_BLACK(N_BLACK), .N_INV_LEAD(N_INV_LEAD),
    .N_VALID(N_VALID), .N_INV_TRAIL(N_INV_TRAIL)
  ) u_map (
    .pix_idx(pix_idx), .region(region_c)
  );

  // phase 1 parks high outside readout; during readout it follows the index parity
  assign ph1_next  = (phase == PH_READ) ? pix_idx[0] : 1'b1;
  assign first_pix = (phase == PH_READ) && (pix_idx == '0) && (pix_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_ph1  <= 1'b1;
      shift_ph2  <= 1'b0;
      reset_gate <= 1'b0;
      line_start <= 1'b0;
      pix_region <= REG_DUMMY;
      sample_en  <= 1'b0;
    end else begin
      shift_ph1  <= ph1_next;
      shift_ph2  <= ~ph1_next;
      reset_gate <= rs_on;
      line_start <= first_pix;
      pix_region <= (phase == PH_READ) ? region_c : REG_DUMMY;
      sample_en  <= (phase == PH_READ) && samp_pt;
    end
  end

  // one output flop per colour gate, all fed by the same window
  for (genvar c = 0; c < N_COLOUR; c++) begin : g_tg
    always_ff @(posedge clk) begin
      if (rst) tg_q[c] <= 1'b0;
      else     tg_q[c] <= tg_on;
    end
  end

  assign tg_red   = tg_q[0];
  assign tg_green = tg_q[1];
  assign tg_blue  = tg_q[2];

  // ---- assertion support counters ----
  localparam logic [CW-1:0] RS_W  = CW'(RS_CYC);
  localparam logic [CW-1:0] GAP_W = CW'(GAP_CYC);
  logic [CW-1:0] rs_run, gap_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_run  <= '0;
      gap_run <= '1;
    end else begin
      rs_run  <= reset_gate ? rs_run + CW'(1) : '0;
      if (reset_gate)       gap_run <= '0;
      else if (gap_run != '1) gap_run <= gap_run + CW'(1);
    end
  end

  // R3: every reset pulse lasts the derived number of cycles
  a_r3_rs_width: assert property (@(posedge clk) disable iff (rst)
    $fell(reset_gate) |-> (rs_run == RS_W));

  // R5: a gate pulse only ever sits under a high phase 1
  a_r5_tg_under_ph1: assert property (@(posedge clk) disable iff (rst)
    tg_red |-> shift_ph1);

  // R7: capture strobe lands in the reset-low part of the pixel
  a_r7_sample_rs_low: assert property (@(posedge clk) disable iff (rst)
    sample_en |-> !reset_gate);

  // R8: line strobe coincides with a reset pulse and never with a gate pulse
  a_r8_start_on_rs: assert property (@(posedge clk) disable iff (rst)
    line_start |-> (reset_gate && !tg_green));

  // R10: a shift edge that comes with a reset rise is preceded by the gap
  a_r10_shift_gap: assert property (@(posedge clk) disable iff (rst)
    (!$stable(shift_ph1) && reset_gate) |-> (gap_run >= GAP_W));

endmodule

// File: tb/sim_ccd_line_sequencer.sv
`timescale 1ns/1ps
module sim_ccd_line_sequencer;

  localparam int CW = 16;
  localparam int TB_D = 4, TB_B = 5, TB_IL = 2, TB_V = 12, TB_IT = 3;
  localparam int TB_TOTAL = TB_D + TB_B + TB_IL + TB_V + TB_IT;
  localparam int RS = 3, MINP = 13, MINT = 150, MING = 45;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic [CW-1:0] cfg_pix = '0, cfg_tg = '0, cfg_guard = '0, cfg_line = '0;
  logic ph1, ph2, tgr, tgg, tgb, rsg, ls, se;
  logic [1:0] code;

  always #10 clk = ~clk;

  ccd_line_sequencer #(
    .CW(CW), .N_DUMMY(TB_D), .N_BLACK(TB_B), .N_INV_LEAD(TB_IL),
    .N_VALID(TB_V), .N_INV_TRAIL(TB_IT)
  ) u0 (
    .clk(clk), .rst(rst), .run(run),
    .cfg_pix_cycles(cfg_pix), .cfg_tg_cycles(cfg_tg),
    .cfg_guard_cycles(cfg_guard), .cfg_line_pixels(cfg_line),
    .shift_ph1(ph1), .shift_ph2(ph2), .tg_red(tgr), .tg_green(tgg), .tg_blue(tgb),
    .reset_gate(rsg), .line_start(ls), .pix_region(code), .sample_en(se)
  );

  int checks = 0, failures = 0;
  int eP, eT, eG, eL, eX;
  int cyc = 0, pos = 0, hi_len = 0, last_rise = 0, ls_cyc = 0, tg_rise = 0, tg_fall = 0;
  int samp_idx = 0, ls_count = 0;
  bit mon_en = 0, have_rise = 0, have_ls = 0, have_tgf = 0;
  logic rs_prev = 1'b0, tg_prev = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_code(input int i);
    if (i < TB_D) return 0;
    if (i < TB_D + TB_B) return 1;
    if (i < TB_D + TB_B + TB_IL) return 2;
    if (i < TB_D + TB_B + TB_IL + TB_V) return 3;
    if (i < TB_TOTAL) return 2;
    return 0;
  endfunction

  function automatic int floor_max(input int v, input int lo);
    return (v < lo) ? lo : v;
  endfunction

  // monitor: outputs are stable at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (mon_en) begin
      if (rsg && !rs_prev) begin
        if (have_rise) chk(cyc - last_rise == eP, "R3/R2 reset period", cyc - last_rise, eP);
        have_rise = 1; last_rise = cyc; pos = 0;
      end else begin
        pos++;
      end
      if (!rsg && rs_prev) chk(hi_len == RS, "R3 reset width", hi_len, RS);
      hi_len = rsg ? hi_len + 1 : 0;
      chk(ph2 == !ph1, "R4 phases complementary", int'(ph2), int'(!ph1));
      chk(tgg == tgr && tgb == tgr, "R5 gates identical", int'({tgr, tgg, tgb}), tgr ? 7 : 0);
      if (tgr && !tg_prev) begin
        chk(ph1, "R5 phase1 high at gate rise", int'(ph1), 1);
        if (have_ls) chk(cyc - ls_cyc == eL * eP + eG, "R5 gate rise after guard", cyc - ls_cyc, eL * eP + eG);
        tg_rise = cyc;
      end
      if (!tgr && tg_prev) begin
        chk(cyc - tg_rise == eT, "R5 gate width", cyc - tg_rise, eT);
        tg_fall = cyc; have_tgf = 1;
      end
      if (se) begin
        chk(!rsg && pos == RS + (eP - RS) / 2, "R7 sample position", pos, RS + (eP - RS) / 2);
        chk(int'(code) == exp_code(samp_idx), "R6 region code", int'(code), exp_code(samp_idx));
        chk(ph1 == samp_idx[0], "R4 phase1 parity", int'(ph1), samp_idx % 2);
        samp_idx++;
      end
      if (ls) begin
        chk(rsg && pos == 0, "R8 start on reset rise", pos, 0);
        if (have_ls) begin
          chk(cyc - ls_cyc == (eX + eL) * eP, "R8 line period", cyc - ls_cyc, (eX + eL) * eP);
          chk(samp_idx == eL, "R2 pixels per line", samp_idx, eL);
        end
        if (have_tgf) chk(cyc - tg_fall == eX * eP - eG - eT, "R5 hold after gate", cyc - tg_fall, eX * eP - eG - eT);
        ls_cyc = cyc; have_ls = 1; samp_idx = 0; ls_count++;
      end
    end
    rs_prev = rsg;
    tg_prev = tgr;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_ls(input int target, input int limit, input string tag);
    int n = 0;
    while (ls_count < target && n < limit) begin
      step(1);
      n++;
    end
    chk(ls_count >= target, tag, ls_count, target);
  endtask

  task automatic run_cfg(input int p, input int t, input int g, input int l);
    int base;
    step(1);
    mon_en = 0; rst = 1; run = 0;
    cfg_pix = CW'(p); cfg_tg = CW'(t); cfg_guard = CW'(g); cfg_line = CW'(l);
    eP = floor_max(p, MINP); eT = floor_max(t, MINT);
    eG = floor_max(g, MING); eL = floor_max(l, TB_TOTAL);
    eX = (2 * eG + eT + eP - 1) / eP;
    step(3);
    // R1 reset state
    chk(ph1 == 1'b1 && ph2 == 1'b0, "R1 phases in reset", int'({ph1, ph2}), 2);
    chk(!tgr && !tgg && !tgb, "R1 gates in reset", int'({tgr, tgg, tgb}), 0);
    chk(!rsg && !ls && !se && code == 2'd0, "R1 strobes in reset", int'({rsg, ls, se, code}), 0);
    have_rise = 0; have_ls = 0; have_tgf = 0; samp_idx = 0; pos = 0; hi_len = 0;
    ls_count = 0; rs_prev = 1'b0; tg_prev = 1'b0;
    mon_en = 1; rst = 0; run = 1;
    step(1);
    chk(ph1 && !rsg && !tgr && !ls, "R1 first cycle after reset", int'({ph1, rsg, tgr, ls}), 8);
    step(1);
    // R2: later cfg changes must be ignored
    cfg_pix = CW'(200); cfg_tg = CW'(9); cfg_guard = CW'(500); cfg_line = CW'(1000);
    wait_ls(3, (eX + 3 * (eX + eL)) * eP + 50, "R9 lines start while running");
    step(5);
    run = 0;
    base = ls_count;
    step((eX + eL + 3) * eP);
    chk(ls_count == base, "R9 no new line after stop", ls_count, base);
    chk(samp_idx == eL, "R9 stopped line completes", samp_idx, eL);
    for (int i = 0; i < 2 * eP; i++) begin
      step(1);
      chk(ph1 && !ph2 && !tgr && !tgg && !tgb && !rsg && !se,
          "R9 parked quiet state", int'({ph1, ph2, tgr, rsg, se}), 16);
    end
    have_rise = 0; have_ls = 0; have_tgf = 0; samp_idx = 0;
    run = 1;
    wait_ls(base + 1, eX * eP + eP + 20, "R9 restart after run returns");
    wait_ls(base + 2, (eX + eL) * eP + 20, "R8 second line after restart");
  endtask

  initial begin
    void'($urandom(32'd7341));
    run_cfg(20, 200, 50, 30);
    run_cfg(5, 10, 3, 4);
    run_cfg(MINP, MINT, MING, TB_TOTAL);
    run_cfg(24, 260, 70, 40);
    for (int k = 0; k < 4; k++) begin
      run_cfg(8 + int'($urandom % 17), 100 + int'($urandom % 161),
              30 + int'($urandom % 41), 20 + int'($urandom % 21));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule